// File: doc/BRIEF.md
# Power-Aware Interrupt Priority Selector

This block chooses which pending asynchronous interrupt a processor core takes next. It reads a vector of pending interrupt lines, the core's machine-state bits and a set of partition control enables. From these it computes an eligibility vector and keeps the highest-priority eligible source. The choice is registered and offered to an interrupt sequencer through a valid/ready pair. While the sequencer has not accepted an offer, the offered choice stays fixed.

When the core is halted in a power-saving state, two rules change the usual gating. If the halted core has its exit-control bit set, only pending sources that the separate wake-enable vector allows can win. Priority among those sources is plain index order. If the exit-control bit is clear, the external-enable gate is treated as open, so any system-caused source wakes the core. If, in that case, the real external-enable bit is clear, the selection carries a skip indication. The core then resumes at the instruction after its sleep instruction and does not take the vector.

Top module: `irq_wake_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `req_valid`, `sel_code`, `sel_onehot` and `sel_deliver` are all zero.
- R2: Source index i has priority over index j when i < j. The index map is: 0 machine check, 1 hypervisor decrementer, 2 hypervisor virtualization, 3 external, 4 decrementer, 5 and above other lower-priority sources. `sel_code` is the winner's index plus one, with 0 meaning no selection. `sel_onehot` has exactly the winner's bit set, or no bit set. `req_valid` is 1 exactly when `sel_code` is nonzero.
- R3: Outside wake mode, a pending machine check (index 0) is always selected, whatever the enable and mode bits are.
- R4: Outside wake mode, index 1 is eligible only when `hdec_en` is 1 and either the effective enable is 1 or `hv` is 0. Index 2 follows the same rule, using `hvirt_en` in place of `hdec_en`.
- R5: Outside wake mode, index 3 is eligible in two cases. The first is when the effective enable is 1 and delivery is not blocked. Delivery is blocked when `hext_block`=1, `hv`=1 and `pr`=0. The second is when `has_hv`=1, `hv`=0 and `ext_guest`=0.
- R6: The effective enable is `ee` OR `resume_rst`. Indices 4 and above are eligible only while the effective enable is 1.
- R7: When `halted`=1 and `exit_ctl`=0, the effective enable is forced to 1.
- R8: When `halted`=1 and `exit_ctl`=1 (wake mode), the candidates are exactly `pend & wake_en`, chosen in index order. No other gating applies.
- R9: `sel_deliver` is 0 when the selection was captured with `halted`=1, `exit_ctl`=0 and `ee`=0. Otherwise it is 1 for a valid selection. `resume_rst` does not count as `ee` for this flag.
- R10: A new selection is captured on the rising clock edge when `req_valid` is 0 or `req_ready` is 1, and it appears one cycle after its inputs. While `req_valid`=1 and `req_ready`=0, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend | input | N | Pending interrupt lines, indexed as in R2 |
| wake_en | input | N | Per-source wake enable, used in wake mode |
| ee | input | 1 | External-enable machine-state bit |
| hv | input | 1 | Hypervisor-mode machine-state bit |
| pr | input | 1 | Problem-state machine-state bit |
| resume_rst | input | 1 | Resume-as-reset flag, widens the enable |
| halted | input | 1 | Core is in a power-saving halt |
| exit_ctl | input | 1 | Power-save exit-control bit |
| has_hv | input | 1 | Core implements hypervisor mode |
| hdec_en | input | 1 | Partition enable for hypervisor decrementer |
| hvirt_en | input | 1 | Partition enable for hypervisor virtualization |
| ext_guest | input | 1 | External interrupts routed to guest (when 0, a guest-mode external goes to the hypervisor) |
| hext_block | input | 1 | Blocks external delivery to hypervisor kernel |
| req_ready | input | 1 | Sequencer accepts the offered selection |
| req_valid | output | 1 | A selection is offered |
| sel_onehot | output | N | One-hot selected source |
| sel_code | output | CW | Selected index plus one, 0 for none |
| sel_deliver | output | 1 | 1: take the vector; 0: resume at next instruction |

## Verification
A wrong gate term shows up as the wrong `sel_code` exactly one cycle after the stimulus that exposes it. A lower-priority source wins, or a gated source appears, or an eligible one is missing. A broken wake-mode or enable override flips the choice between the wake-vector path and the normal path. It can also flip `sel_deliver`, visible on the next offered selection. A faulty capture condition shows as an output that changes while the sequencer stalls, or as a fresh selection lost for a cycle once the stall clears.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  // Source index map; the order is the priority order.
  localparam int unsigned SRC_MCHK  = 0;
  localparam int unsigned SRC_HDEC  = 1;
  localparam int unsigned SRC_HVIRT = 2;
  localparam int unsigned SRC_EXT   = 3;
  localparam int unsigned SRC_DEC   = 4;
  localparam int unsigned SRC_LOW   = 5;

  typedef struct packed {
    logic ee;
    logic hv;
    logic pr;
    logic resume_rst;
    logic halted;
    logic exit_ctl;
  } core_state_t;

  typedef struct packed {
    logic has_hv;
    logic hdec_en;
    logic hvirt_en;
    logic ext_guest;
    logic hext_block;
  } part_ctl_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_wake_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] pend,
  input  logic [N-1:0] wake_en,
  input  core_state_t  cs,
  input  part_ctl_t    pc,
  output logic [N-1:0] cand,
  output logic         ee_eff,
  output logic         wake_mode,
  output logic         deliver
);
  logic [N-1:0] elig;
  logic         hv_open;
  logic         ext_blocked;

  function automatic logic eff_enable(input core_state_t s);
    return s.ee | s.resume_rst | (s.halted & ~s.exit_ctl);
  endfunction

  assign ee_eff      = eff_enable(cs);
  assign wake_mode   = cs.halted & cs.exit_ctl;
  assign hv_open     = ee_eff | ~cs.hv;
  assign ext_blocked = pc.hext_block & cs.hv & ~cs.pr;

  assign elig[SRC_MCHK]  = pend[SRC_MCHK];
  assign elig[SRC_HDEC]  = pend[SRC_HDEC]  & pc.hdec_en  & hv_open;
  assign elig[SRC_HVIRT] = pend[SRC_HVIRT] & pc.hvirt_en & hv_open;
  assign elig[SRC_EXT]   = pend[SRC_EXT] &
                           ((ee_eff & ~ext_blocked) |
                            (pc.has_hv & ~cs.hv & ~pc.ext_guest));
  assign elig[SRC_DEC]   = pend[SRC_DEC] & ee_eff;

  genvar k;
  generate
    for (k = SRC_LOW; k < N; k++) begin : g_low
      assign elig[k] = pend[k] & ee_eff;
    end
  endgenerate

  assign cand    = wake_mode ? (pend & wake_en) : elig;
  assign deliver = ~(cs.halted & ~cs.exit_ctl & ~cs.ee);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  onehot,
  output logic [CW-1:0] code
);
  function automatic logic [CW-1:0] first_code(input logic [N-1:0] r);
    logic [CW-1:0] c;
    c = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (r[i]) c = CW'(i + 1);
    end
    return c;
  endfunction

  assign onehot = req & (~req + N'(1));
  assign code   = first_code(req);
endmodule

// File: rtl/irq_hold_reg.sv
module irq_hold_reg #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  onehot_in,
  input  logic [CW-1:0] code_in,
  input  logic          deliver_in,
  output logic          valid_q,
  output logic [N-1:0]  onehot_q,
  output logic [CW-1:0] code_q,
  output logic          deliver_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      onehot_q  <= '0;
      code_q    <= '0;
      deliver_q <= 1'b0;
    end else if (load) begin
      valid_q   <= |onehot_in;
      onehot_q  <= onehot_in;
      code_q    <= code_in;
      deliver_q <= deliver_in & (|onehot_in);
    end
  end
endmodule

// File: rtl/irq_wake_arbiter.sv
module irq_wake_arbiter
  import irq_wake_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             pend,
  input  logic [N-1:0]             wake_en,
  input  logic                     ee,
  input  logic                     hv,
  input  logic                     pr,
  input  logic                     resume_rst,
  input  logic                     halted,
  input  logic                     exit_ctl,
  input  logic                     has_hv,
  input  logic                     hdec_en,
  input  logic                     hvirt_en,
  input  logic                     ext_guest,
  input  logic                     hext_block,
  input  logic                     req_ready,
  output logic                     req_valid,
  output logic [N-1:0]             sel_onehot,
  output logic [$clog2(N+1)-1:0]   sel_code,
  output logic                     sel_deliver
);
  localparam int CW = $clog2(N + 1);

  core_state_t   cs;
  part_ctl_t     pc;
  logic [N-1:0]  cand_w;
  logic [N-1:0]  pick_onehot_w;
  logic [CW-1:0] pick_code_w;
  logic          ee_eff_w;
  logic          wake_mode_w;
  logic          deliver_w;
  logic          load_w;

  assign cs = '{ee: ee, hv: hv, pr: pr, resume_rst: resume_rst,
                halted: halted, exit_ctl: exit_ctl};
  assign pc = '{has_hv: has_hv, hdec_en: hdec_en, hvirt_en: hvirt_en,
                ext_guest: ext_guest, hext_block: hext_block};

  irq_gate #(.N(N)) u_gate (
    .pend      (pend),
    .wake_en   (wake_en),
    .cs        (cs),
    .pc        (pc),
    .cand      (cand_w),
    .ee_eff    (ee_eff_w),
    .wake_mode (wake_mode_w),
    .deliver   (deliver_w)
  );

  irq_prio_pick #(.N(N), .CW(CW)) u_pick (
    .req    (cand_w),
    .onehot (pick_onehot_w),
    .code   (pick_code_w)
  );

  assign load_w = ~req_valid | req_ready;

  irq_hold_reg #(.N(N), .CW(CW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_w),
    .onehot_in  (pick_onehot_w),
    .code_in    (pick_code_w),
    .deliver_in (deliver_w),
    .valid_q    (req_valid),
    .onehot_q   (sel_onehot),
    .code_q     (sel_code),
    .deliver_q  (sel_deliver)
  );
endmodule

// File: rtl/irq_wake_arbiter_chk.sv
module irq_wake_arbiter_chk #(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  wake_en,
  input logic          ee,
  input logic          halted,
  input logic          exit_ctl,
  input logic          req_ready,
  input logic          req_valid,
  input logic [N-1:0]  sel_onehot,
  input logic [CW-1:0] sel_code,
  input logic          sel_deliver,
  input logic          load_w,
  input logic          wake_mode_w,
  input logic          ee_eff_w
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot)); // R2

  AST_VALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (sel_code != '0)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(sel_code) && $stable(sel_deliver)); // R10

  AST_MCHK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_w && pend[0] && !wake_mode_w |=> sel_code == CW'(1)); // R3

  AST_WAKE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    load_w && wake_mode_w && ((pend & wake_en) == '0) |=> !req_valid); // R8

  AST_DEC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    load_w && !wake_mode_w && !ee_eff_w && ((pend & ~(N'(1) << 4)) == '0) |=> !req_valid); // R6

  AST_SKIP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    load_w && halted && !exit_ctl && !ee |=> !sel_deliver); // R9
endmodule

bind irq_wake_arbiter irq_wake_arbiter_chk #(.N(N), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend        (pend),
  .wake_en     (wake_en),
  .ee          (ee),
  .halted      (halted),
  .exit_ctl    (exit_ctl),
  .req_ready   (req_ready),
  .req_valid   (req_valid),
  .sel_onehot  (sel_onehot),
  .sel_code    (sel_code),
  .sel_deliver (sel_deliver),
  .load_w      (load_w),
  .wake_mode_w (wake_mode_w),
  .ee_eff_w    (ee_eff_w)
);

// File: tb/sim_irq_wake_arbiter.sv
`timescale 1ns/1ps
module sim_irq_wake_arbiter;
  localparam int N  = 8;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pend = '0, wake_en = '0;
  logic ee = 0, hv = 0, pr = 0, resume_rst = 0, halted = 0, exit_ctl = 0;
  logic has_hv = 0, hdec_en = 0, hvirt_en = 0, ext_guest = 0, hext_block = 0;
  logic req_ready = 1'b1;
  logic req_valid, sel_deliver;
  logic [N-1:0] sel_onehot;
  logic [CW-1:0] sel_code;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_code = 0;
  bit exp_valid = 0, exp_del = 0;

  always #2 clk = ~clk;

  irq_wake_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pend(pend), .wake_en(wake_en), .ee(ee), .hv(hv),
    .pr(pr), .resume_rst(resume_rst), .halted(halted), .exit_ctl(exit_ctl),
    .has_hv(has_hv), .hdec_en(hdec_en), .hvirt_en(hvirt_en), .ext_guest(ext_guest),
    .hext_block(hext_block), .req_ready(req_ready), .req_valid(req_valid),
    .sel_onehot(sel_onehot), .sel_code(sel_code), .sel_deliver(sel_deliver)
  );

  // Reference selection written as a walk down the priority list.
  function automatic int ref_code();
    bit open;
    if (halted && exit_ctl) begin
      for (int i = 0; i < N; i++) if (pend[i] && wake_en[i]) return i + 1;
      return 0;
    end
    open = ee || resume_rst || halted;
    if (pend[0]) return 1;
    if (pend[1] && hdec_en && (open || !hv)) return 2;
    if (pend[2] && hvirt_en && (open || !hv)) return 3;
    if (pend[3] && ((open && !(hext_block && hv && !pr)) || (has_hv && !hv && !ext_guest)))
      return 4;
    if (open) for (int i = 4; i < N; i++) if (pend[i]) return i + 1;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // One clock: predict at the edge, compare at the following falling edge.
  task automatic step(input string tag);
    int c;
    bit d;
    c = ref_code();
    d = !(halted && !exit_ctl && !ee);
    if (!exp_valid || req_ready) begin
      exp_code = c;
      exp_valid = (c != 0);
      exp_del = (c != 0) && d;
    end
    @(negedge clk);
    chk(int'(sel_code) == exp_code, tag, int'(sel_code), exp_code);
    chk(req_valid == exp_valid, {tag, " valid"}, int'(req_valid), int'(exp_valid));
    chk(sel_onehot == (exp_code == 0 ? N'(0) : (N'(1) << (exp_code - 1))),
        {tag, " onehot"}, int'(sel_onehot), exp_code);
    if (exp_valid) chk(sel_deliver == exp_del, {tag, " deliver"}, int'(sel_deliver), int'(exp_del));
  endtask

  task automatic clear_in();
    pend = '0; wake_en = '0; ee = 0; hv = 0; pr = 0; resume_rst = 0; halted = 0;
    exit_ctl = 0; has_hv = 0; hdec_en = 0; hvirt_en = 0; ext_guest = 0; hext_block = 0;
    req_ready = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    pend = 8'hFF; ee = 1;
    repeat (3) @(negedge clk);
    chk(!req_valid && sel_code == 0 && sel_onehot == 0 && !sel_deliver, "R1 in reset",
        int'(sel_code), 0);
    clear_in();
    rst_n = 1;
    @(negedge clk);
    chk(!req_valid && sel_code == 0, "R1 after reset", int'(sel_code), 0);

    // R3: machine check with every gate shut
    pend = 8'hFF; hv = 1; step("R3 mchk ungated");
    // R4
    clear_in(); pend = 8'h02; step("R4 hdec disabled");
    hdec_en = 1; hv = 1; step("R4 hdec hv no ee");
    hv = 0; step("R4 hdec guest");
    pend = 8'h04; hvirt_en = 1; hv = 1; ee = 1; step("R4 hvirt ee");
    // R5
    clear_in(); pend = 8'h08; ee = 1; hext_block = 1; hv = 1; step("R5 ext blocked");
    pr = 1; step("R5 ext unblocked by pr");
    clear_in(); pend = 8'h08; has_hv = 1; step("R5 ext guest route");
    ext_guest = 1; step("R5 ext to guest no ee");
    // R6 and R2 priority
    clear_in(); pend = 8'h10; step("R6 dec gated");
    resume_rst = 1; step("R6 dec resume");
    clear_in(); pend = 8'h90; ee = 1; step("R2 dec beats low");
    pend = 8'h80; step("R6 lowest source");
    // R7 and R9
    clear_in(); pend = 8'h10; halted = 1; step("R7 halted forces enable");
    chk(sel_deliver == 0, "R9 skip on wake", int'(sel_deliver), 0);
    ee = 1; step("R9 deliver with ee");
    resume_rst = 1; ee = 0; step("R9 resume_rst not ee");
    // R8
    clear_in(); halted = 1; exit_ctl = 1; pend = 8'h11; wake_en = 8'h10; step("R8 wake filter");
    wake_en = 8'h00; ee = 1; step("R8 nothing enabled");
    // R10 hold
    clear_in(); pend = 8'h20; ee = 1; step("R10 load");
    req_ready = 0; pend = 8'h01; step("R10 hold");
    step("R10 hold again");
    req_ready = 1; step("R10 accept");
    step("R10 reload");

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      pend = N'($urandom); wake_en = N'($urandom);
      if ($urandom_range(0, 3) == 0) pend[0] = 0;
      pend = ($urandom_range(0, 1) == 1) ? (pend & ~N'(1)) : pend;
      {ee, hv, pr, resume_rst} = 4'($urandom);
      halted = ($urandom_range(0, 2) == 0); exit_ctl = $urandom_range(0, 1) == 1;
      {has_hv, hdec_en, hvirt_en, ext_guest, hext_block} = 5'($urandom);
      req_ready = ($urandom_range(0, 3) != 0);
      step("R2 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule